// File: doc/BRIEF.md
# Dual-Format Raster Timing Generator

This block produces the line and frame timing for a display that can be driven in one of two raster formats. Format 0 is a slow legacy scan with 768 pixel clocks per line and 320 lines per frame. It has positive sync pulses and a single blanking region on each axis. Format 1 is a 640x480-class scan with 800 clocks per line and 525 lines per frame. It has negative sync pulses, and its blanking is split into two regions on each axis, so that a 512x256 picture sits in the centre of the visible area.

The block contains one horizontal counter and one vertical counter, and both formats share them. The horizontal counter advances on every clock cycle on which `pix_en` is high. The vertical counter advances on the clock where the horizontal sync enters its active level. The format input is sampled only when a frame ends. If the format has changed, both counters restart at zero in the new format. Every output comes from a register, and each output is the decode of the count values held in the same register stage. All window limits are parameters. The values given below are the defaults.

Top module: `raster_timing`

## Requirements
- R1: While `rst` is high, both counters are cleared and the active format is loaded from `mode_sel`. `hsync` and `vsync` sit at the inactive level of that format (0 for format 0, 1 for format 1), `hblank` and `vblank` are 1, and `hpulse` and `vpulse` are 0.
- R2: On a clock where `pix_en` is low and `rst` is low, no output changes.
- R3: The horizontal count runs from 0 to the line length minus 1 (767 in format 0, 799 in format 1) and then wraps to 0. `hpulse` is 1 for exactly the one enabled cycle in which the count is at that last value.
- R4: In format 0, `hsync` is 1 for horizontal counts 576 to 639 and 0 at all other counts. In format 1, `hsync` is 0 for counts 0 to 95 and 1 at all other counts.
- R5: In format 0, `hblank` is 1 for horizontal counts 512 and above. In format 1, `hblank` is 1 for counts up to 255 and for counts 768 and above.
- R6: The vertical count advances by one, wrapping after the frame length minus 1 (319 or 524), on the enabled cycle where the horizontal count becomes the first count of the sync window (576 in format 0, 0 in format 1).
- R7: In format 0, `vsync` is 1 for lines 280 to 319. In format 1, `vsync` is 0 for lines 0 to 3. Outside those lines `vsync` is at the inactive level of the format.
- R8: In format 0, `vblank` is 1 for lines 256 and above. In format 1, `vblank` is 1 for lines up to 127 and for lines 384 and above.
- R9: `vpulse` is 1 for the whole of the last line of the frame and 0 on every other line.
- R10: A change on `mode_sel` takes effect only when the vertical count wraps. On that cycle the horizontal and vertical counts both restart at 0, and the outputs decode the new format. A change that is undone before the frame ends has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel clock enable |
| mode_sel | input | 1 | Requested format: 0 legacy, 1 VGA-class |
| hsync | output | 1 | Horizontal sync, polarity set by format |
| vsync | output | 1 | Vertical sync, polarity set by format |
| hblank | output | 1 | Horizontal blanking, active high |
| vblank | output | 1 | Vertical blanking, active high |
| hpulse | output | 1 | One-clock pulse at end of line |
| vpulse | output | 1 | One-line pulse at end of frame |

## Verification
The bench uses a scaled-down geometry, so that many whole frames of both formats fit into a short run. A random `pix_en` duty separates counting on enabled cycles from counting on every cycle. A directed stretch with the enable low shows that the outputs hold. `mode_sel` is toggled at random points in the frame, including toggles that are undone before the frame ends. This separates a switch taken at the frame boundary from one taken at once, and it shows whether both counters restart. Resets in either format check the inactive levels, which differ between the formats.

// File: rtl/raster_timing.sv
module raster_timing #(
  parameter int H0_TOTAL     = 768,
  parameter int H0_SYNC_BEG  = 576,
  parameter int H0_SYNC_END  = 639,
  parameter int H0_BLANK_BEG = 512,
  parameter int H1_TOTAL     = 800,
  parameter int H1_SYNC_BEG  = 0,
  parameter int H1_SYNC_END  = 95,
  parameter int H1_BLANK_LO  = 255,
  parameter int H1_BLANK_HI  = 768,
  parameter int V0_TOTAL     = 320,
  parameter int V0_SYNC_BEG  = 280,
  parameter int V0_SYNC_END  = 319,
  parameter int V0_BLANK_BEG = 256,
  parameter int V1_TOTAL     = 525,
  parameter int V1_SYNC_BEG  = 0,
  parameter int V1_SYNC_END  = 3,
  parameter int V1_BLANK_LO  = 127,
  parameter int V1_BLANK_HI  = 384
) (
  input  logic clk,
  input  logic rst,
  input  logic pix_en,
  input  logic mode_sel,
  output logic hsync,
  output logic vsync,
  output logic hblank,
  output logic vblank,
  output logic hpulse,
  output logic vpulse
);
  localparam int HMAX = (H0_TOTAL > H1_TOTAL) ? H0_TOTAL : H1_TOTAL;
  localparam int VMAX = (V0_TOTAL > V1_TOTAL) ? V0_TOTAL : V1_TOTAL;
  localparam int HW = $clog2(HMAX);
  localparam int VW = $clog2(VMAX);

  function automatic logic hwin(input logic [HW-1:0] v, input int b, input int e);
    return HW'(v - HW'(b)) <= HW'(e - b);
  endfunction

  function automatic logic vwin(input logic [VW-1:0] v, input int b, input int e);
    return VW'(v - VW'(b)) <= VW'(e - b);
  endfunction

  logic [HW-1:0] hcnt, h_inc, h_nx, h_last, h_edge;
  logic [VW-1:0] vcnt, v_nx, v_last;
  logic mode_q, m_nx, v_step, frame_end, swap;
  logic hs_on, vs_on, hb_on, vb_on;

  assign h_last    = mode_q ? HW'(H1_TOTAL - 1) : HW'(H0_TOTAL - 1);
  assign h_edge    = mode_q ? HW'(H1_SYNC_BEG) : HW'(H0_SYNC_BEG);
  assign v_last    = mode_q ? VW'(V1_TOTAL - 1) : VW'(V0_TOTAL - 1);
  assign h_inc     = (hcnt == h_last) ? '0 : hcnt + 1'b1;
  assign v_step    = (h_inc == h_edge);
  assign frame_end = v_step && (vcnt == v_last);
  assign v_nx      = v_step ? (frame_end ? '0 : vcnt + 1'b1) : vcnt;
  assign swap      = frame_end && (mode_sel != mode_q);
  assign m_nx      = swap ? mode_sel : mode_q;
  assign h_nx      = swap ? '0 : h_inc;

  assign hs_on = m_nx ? hwin(h_nx, H1_SYNC_BEG, H1_SYNC_END)
                      : hwin(h_nx, H0_SYNC_BEG, H0_SYNC_END);
  assign vs_on = m_nx ? vwin(v_nx, V1_SYNC_BEG, V1_SYNC_END)
                      : vwin(v_nx, V0_SYNC_BEG, V0_SYNC_END);
  assign hb_on = m_nx ? (h_nx <= HW'(H1_BLANK_LO) || h_nx >= HW'(H1_BLANK_HI))
                      : (h_nx >= HW'(H0_BLANK_BEG));
  assign vb_on = m_nx ? (v_nx <= VW'(V1_BLANK_LO) || v_nx >= VW'(V1_BLANK_HI))
                      : (v_nx >= VW'(V0_BLANK_BEG));

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt   <= '0;
      vcnt   <= '0;
      mode_q <= mode_sel;
      hsync  <= mode_sel;
      vsync  <= mode_sel;
      hblank <= 1'b1;
      vblank <= 1'b1;
      hpulse <= 1'b0;
      vpulse <= 1'b0;
    end else if (pix_en) begin
      hcnt   <= h_nx;
      vcnt   <= v_nx;
      mode_q <= m_nx;
      hsync  <= hs_on ^ m_nx;
      vsync  <= vs_on ^ m_nx;
      hblank <= hb_on;
      vblank <= vb_on;
      hpulse <= (h_nx == (m_nx ? HW'(H1_TOTAL - 1) : HW'(H0_TOTAL - 1)));
      vpulse <= (v_nx == (m_nx ? VW'(V1_TOTAL - 1) : VW'(V0_TOTAL - 1)));
    end
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> $stable({hsync, vsync, hblank, vblank, hpulse, vpulse}));

  // R3
  hpulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    (hpulse && pix_en) |=> !hpulse);

  // R4
  hsync_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (hsync != mode_q) |-> hblank);

  // R9
  vpulse_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
    vpulse |-> vblank);

  // R10
  mode_at_origin_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_q) |-> (hcnt == '0 && vcnt == '0));
endmodule

// File: tb/sim_raster_timing.sv
module sim_raster_timing;
  localparam int H0T = 48, H0SB = 36, H0SE = 39, H0BB = 32;
  localparam int H1T = 50, H1SB = 0,  H1SE = 5,  H1BL = 15, H1BH = 48;
  localparam int V0T = 20, V0SB = 17, V0SE = 19, V0BB = 16;
  localparam int V1T = 33, V1SB = 0,  V1SE = 1,  V1BL = 7,  V1BH = 24;
  localparam int NCYC = 24000;

  logic clk = 1'b0;
  logic rst = 1'b1, pix_en = 1'b0, mode_sel = 1'b0;
  logic hsync, vsync, hblank, vblank, hpulse, vpulse;
  int compared = 0, mismatched = 0;

  always #4 clk = ~clk;

  raster_timing #(
    .H0_TOTAL(H0T), .H0_SYNC_BEG(H0SB), .H0_SYNC_END(H0SE), .H0_BLANK_BEG(H0BB),
    .H1_TOTAL(H1T), .H1_SYNC_BEG(H1SB), .H1_SYNC_END(H1SE), .H1_BLANK_LO(H1BL), .H1_BLANK_HI(H1BH),
    .V0_TOTAL(V0T), .V0_SYNC_BEG(V0SB), .V0_SYNC_END(V0SE), .V0_BLANK_BEG(V0BB),
    .V1_TOTAL(V1T), .V1_SYNC_BEG(V1SB), .V1_SYNC_END(V1SE), .V1_BLANK_LO(V1BL), .V1_BLANK_HI(V1BH)
  ) u0 (
    .clk(clk), .rst(rst), .pix_en(pix_en), .mode_sel(mode_sel),
    .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank),
    .hpulse(hpulse), .vpulse(vpulse)
  );

  int mh = 0, mv = 0;
  logic mm = 1'b0;
  logic e_hs, e_vs, e_hb, e_vb, e_hp, e_vp;
  string tag_h, tag_v;

  function automatic logic exp_hs(logic m, int h);
    return m ? !(h >= H1SB && h <= H1SE) : (h >= H0SB && h <= H0SE);
  endfunction
  function automatic logic exp_vs(logic m, int v);
    return m ? !(v >= V1SB && v <= V1SE) : (v >= V0SB && v <= V0SE);
  endfunction
  function automatic logic exp_hb(logic m, int h);
    return m ? (h <= H1BL || h >= H1BH) : (h >= H0BB);
  endfunction
  function automatic logic exp_vb(logic m, int v);
    return m ? (v <= V1BL || v >= V1BH) : (v >= V0BB);
  endfunction

  task automatic chk(string req, string nm, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b (t=%0t)", req, nm, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int htot, vtot, hedge;
    logic stepped, swapped;
    htot  = mm ? H1T : H0T;
    vtot  = mm ? V1T : V0T;
    hedge = mm ? H1SB : H0SB;
    mh = (mh + 1) % htot;
    stepped = (mh == hedge);
    swapped = 1'b0;
    if (stepped) begin
      mv = (mv + 1) % vtot;
      if (mv == 0 && mode_sel != mm) begin
        mm = mode_sel;
        mh = 0;
        swapped = 1'b1;
      end
    end
    e_hs = exp_hs(mm, mh);
    e_vs = exp_vs(mm, mv);
    e_hb = exp_hb(mm, mh);
    e_vb = exp_vb(mm, mv);
    e_hp = (mh == (mm ? H1T : H0T) - 1);
    e_vp = (mv == (mm ? V1T : V0T) - 1);
    tag_h = swapped ? "R10" : "";
    tag_v = swapped ? "R10" : (stepped ? "R6" : "");
  endtask

  initial begin
    logic last_rst, last_en;
    int next_toggle;
    void'($urandom(32'd20240611));
    last_rst = 1'b1;
    last_en = 1'b0;
    next_toggle = 3000;
    e_hs = 1'b0; e_vs = 1'b0; e_hb = 1'b1; e_vb = 1'b1; e_hp = 1'b0; e_vp = 1'b0;
    tag_h = ""; tag_v = "";
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      if (cyc > 0) begin
        if (last_rst) begin
          chk("R1", "hsync", hsync, e_hs);
          chk("R1", "vsync", vsync, e_vs);
          chk("R1", "hblank", hblank, e_hb);
          chk("R1", "vblank", vblank, e_vb);
          chk("R1", "hpulse", hpulse, e_hp);
          chk("R1", "vpulse", vpulse, e_vp);
        end else if (!last_en) begin
          chk("R2", "hsync", hsync, e_hs);
          chk("R2", "vsync", vsync, e_vs);
          chk("R2", "hblank", hblank, e_hb);
          chk("R2", "vblank", vblank, e_vb);
          chk("R2", "hpulse", hpulse, e_hp);
          chk("R2", "vpulse", vpulse, e_vp);
        end else begin
          chk(tag_h != "" ? tag_h : "R4", "hsync", hsync, e_hs);
          chk(tag_h != "" ? tag_h : "R5", "hblank", hblank, e_hb);
          chk(tag_h != "" ? tag_h : "R3", "hpulse", hpulse, e_hp);
          chk(tag_v != "" ? tag_v : "R7", "vsync", vsync, e_vs);
          chk(tag_v != "" ? tag_v : "R8", "vblank", vblank, e_vb);
          chk(tag_v != "" ? tag_v : "R9", "vpulse", vpulse, e_vp);
        end
      end
      // stimulus: directed phases mixed with random enable, toggles and resets
      if (cyc < 6) begin
        rst = 1'b1; mode_sel = 1'b0; pix_en = 1'b1;
      end else if (cyc >= 12000 && cyc < 12004) begin
        rst = 1'b1; mode_sel = 1'b1; pix_en = ($urandom % 2) == 0;
      end else if (cyc >= 2500 && cyc < 2530) begin
        rst = 1'b0; pix_en = 1'b0;
      end else begin
        rst = ($urandom % 4000) == 0;
        pix_en = cyc < 1000 ? 1'b1 : (($urandom % 4) != 0);
        if (cyc == next_toggle) begin
          mode_sel = ~mode_sel;
          next_toggle = cyc + 200 + int'($urandom % 1800);
        end
      end
      if (rst) begin
        mm = mode_sel; mh = 0; mv = 0;
        e_hs = mode_sel; e_vs = mode_sel; e_hb = 1'b1; e_vb = 1'b1;
        e_hp = 1'b0; e_vp = 1'b0;
      end else if (pix_en) begin
        model_step();
      end
      last_rst = rst;
      last_en = pix_en;
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 60000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule